// File: doc/BRIEF.md
# Luma Threshold Binarizer and Word Packer

This block receives a stream of 8-bit luminance samples, each tagged with frame-start and line-end markers, and turns it into a stream of 32-bit word writes for a frame buffer. It has two packing modes. In one-bit mode each luma sample is compared with a programmable threshold, and the resulting bits are packed thirty-two to a word. In eight-bit mode the raw luma bytes are packed four to a word. Samples tagged as chroma never reach the output.

Each write has a word address. The first word of a line sits at the frame's base address plus the line index times the line stride, and the words of the line follow at consecutive addresses. The stride is given in pixels and is rounded down to the granule that the active mode requires, so every line starts on a word boundary. The block sits between a sensor front end and a memory write path, and leaves arbitration and bursting to the logic downstream.

Top module: `luma_bin_packer`

## Requirements
- R1: After reset `wr_valid` is low, and it stays low while no sample arrives.
- R2: In one-bit mode a luma sample produces bit 1 when it is greater than or equal to `cfg_thresh`, and bit 0 otherwise.
- R3: In one-bit mode the first pixel of each group of 32 goes to bit 31 of the word and later pixels fill downward. A full word is written after its 32nd pixel.
- R4: In eight-bit mode the first sample of each group of four goes to bits [7:0], the next to [15:8], and so on. A full word is written after its 4th sample.
- R5: A sample with `in_chroma` high adds nothing to any word, in both modes.
- R6: At a line end a partly filled word is written with its unused bits zero. If no pixel is pending at the line end, no extra write happens.
- R7: The words of a line take consecutive word addresses. The first word of line k of a frame is at base word address + k × stride words.
- R8: In one-bit mode the stride in words is `cfg_stride` divided by 32 (the low 5 bits are ignored). In eight-bit mode it is `cfg_stride` divided by 4 (the low 2 bits are ignored).
- R9: The base word address is `cfg_base_addr[31:2]`; bits [1:0] have no effect.
- R10: A sample marked with `in_sof` resets the line index to 0, so the first word of that line is written at the base word address.
- R11: A write appears on the output exactly one clock after the sample that completes or ends its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bin_en | input | 1 | 1 selects one-bit mode, 0 selects eight-bit mode |
| cfg_thresh | input | 8 | Threshold for binarization |
| cfg_base_addr | input | 32 | Frame base byte address (bits [1:0] ignored) |
| cfg_stride | input | 14 | Line stride in pixels |
| in_valid | input | 1 | A sample is present this cycle |
| in_chroma | input | 1 | The sample is a chroma component and is dropped |
| in_sof | input | 1 | The sample is the first of a frame |
| in_eol | input | 1 | The sample is the last of a line |
| in_data | input | 8 | Sample value |
| wr_valid | output | 1 | A word write is presented |
| wr_addr | output | 30 | Word address of the write |
| wr_data | output | 32 | Packed word |

## Verification
On every cycle the assertions check four things: a line-ending luma sample is followed one clock later by a write, a chroma sample that does not end a line produces no write, a word written at frame start lands on the base word address, and a one-bit flush leaves its unused low bits zero. Other behaviour only shows up in the bench's scenarios: the threshold boundary values, the bit and byte ordering inside words, the stride rounding in each mode, the line-to-line address steps across several lines, and the absence of an extra write when a line ends on a word boundary behind a chroma sample. The bench checks these against a scoreboard that it computes independently of the RTL.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
  typedef enum logic {
    PACK_Y8 = 1'b0,
    PACK_Y1 = 1'b1
  } pack_mode_e;
endpackage

// File: rtl/lbp_binarize.sv
module lbp_binarize #(
  parameter int LUMA_W = 8
) (
  input  logic [LUMA_W-1:0] luma,
  input  logic [LUMA_W-1:0] thresh,
  output logic              bit_out
);
  // R2: at or above threshold gives 1
  always_comb begin
    bit_out = (luma >= thresh);
  end
endmodule

// File: rtl/lbp_packer.sv
module lbp_packer
  import lbp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LUMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pack_mode_e        mode,
  input  logic              take_luma,
  input  logic              take_chroma,
  input  logic              eol,
  input  logic [LUMA_W-1:0] luma,
  input  logic              luma_bit,
  output logic              emit,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int LANES = WORD_W / LUMA_W;
  localparam int LN_W  = $clog2(LANES);

  logic [WORD_W-1:0] acc_q, acc_d, merged;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full;

  always_comb begin
    merged = acc_q;
    full   = 1'b0;
    if (mode == PACK_Y1) begin
      // R3: first pixel lands in the top bit
      merged[CNT_W'(WORD_W-1) - cnt_q] = luma_bit;
      full = (cnt_q == CNT_W'(WORD_W-1));
    end else begin
      // R4: first sample lands in the low lane
      merged[cnt_q[LN_W-1:0]*LUMA_W +: LUMA_W] = luma;
      full = (cnt_q[LN_W-1:0] == LN_W'(LANES-1));
    end
  end

  always_comb begin
    emit  = 1'b0;
    word  = merged;
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (take_luma) begin
      if (full || eol) begin
        emit  = 1'b1;
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = merged;
        cnt_d = cnt_q + 1'b1;
      end
    end else if (take_chroma && eol) begin
      // R6: flush only a word that holds pixels
      word  = acc_q;
      emit  = (cnt_q != '0);
      acc_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take_luma || take_chroma) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assert_flush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_luma && eol && mode == PACK_Y1) |-> ((word << (cnt_q + 1'b1)) == '0));
endmodule

// File: rtl/lbp_addr_gen.sv
module lbp_addr_gen
  import lbp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 14,
  parameter int WORD_W   = 32,
  parameter int LUMA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pack_mode_e          mode,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                step,
  input  logic                sof,
  input  logic                eol,
  input  logic                emit,
  output logic [ADDR_W-3:0]   addr
);
  localparam int WA    = ADDR_W - 2;
  localparam int Y1_SH = $clog2(WORD_W);
  localparam int Y8_SH = $clog2(WORD_W / LUMA_W);

  logic [WA-1:0] line_q, line_d, line_cur;
  logic [WA-1:0] off_q, off_d, off_cur;
  logic [WA-1:0] stride_w;

  always_comb begin
    // R8: stride rounded down to the mode granule
    stride_w = (mode == PACK_Y1) ? WA'(stride >> Y1_SH) : WA'(stride >> Y8_SH);
    // R9/R10: frame start reloads the word-aligned base
    line_cur = sof ? base_addr[ADDR_W-1:2] : line_q;
    off_cur  = sof ? '0 : off_q;
    addr     = line_cur + off_cur;
    // R7: step to the next line at line end
    line_d   = eol ? (line_cur + stride_w) : line_cur;
    off_d    = eol ? '0 : (emit ? off_cur + 1'b1 : off_cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      off_q  <= '0;
    end else if (step) begin
      line_q <= line_d;
      off_q  <= off_d;
    end
  end
endmodule

// File: rtl/luma_bin_packer.sv
module luma_bin_packer
  import lbp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 14,
  parameter int WORD_W   = 32,
  parameter int LUMA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_bin_en,
  input  logic [LUMA_W-1:0]   cfg_thresh,
  input  logic [ADDR_W-1:0]   cfg_base_addr,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic                in_valid,
  input  logic                in_chroma,
  input  logic                in_sof,
  input  logic                in_eol,
  input  logic [LUMA_W-1:0]   in_data,
  output logic                wr_valid,
  output logic [ADDR_W-3:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_data
);
  pack_mode_e        mode;
  logic              take_luma, take_chroma, luma_bit, emit_c;
  logic [WORD_W-1:0] word_c;
  logic [ADDR_W-3:0] addr_c;
  logic              wr_valid_q;
  logic [ADDR_W-3:0] wr_addr_q;
  logic [WORD_W-1:0] wr_data_q;

  always_comb begin
    mode        = cfg_bin_en ? PACK_Y1 : PACK_Y8;
    take_luma   = in_valid && !in_chroma;   // R5: chroma never packed
    take_chroma = in_valid && in_chroma;
  end

  lbp_binarize #(.LUMA_W(LUMA_W)) u_bin (
    .luma(in_data), .thresh(cfg_thresh), .bit_out(luma_bit)
  );

  lbp_packer #(.WORD_W(WORD_W), .LUMA_W(LUMA_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .mode(mode), .take_luma(take_luma),
    .take_chroma(take_chroma), .eol(in_eol), .luma(in_data),
    .luma_bit(luma_bit), .emit(emit_c), .word(word_c)
  );

  lbp_addr_gen #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .WORD_W(WORD_W),
                 .LUMA_W(LUMA_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .mode(mode), .base_addr(cfg_base_addr),
    .stride(cfg_stride), .step(in_valid), .sof(in_sof), .eol(in_eol),
    .emit(emit_c), .addr(addr_c)
  );

  // R11: one register stage to the write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_valid_q <= 1'b0;
    else        wr_valid_q <= emit_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (emit_c) begin
      wr_addr_q <= addr_c;
      wr_data_q <= word_c;
    end
  end

  assign wr_valid = wr_valid_q;
  assign wr_addr  = wr_addr_q;
  assign wr_data  = wr_data_q;

  assert_eol_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_chroma && in_eol) |=> wr_valid);
  assert_chroma_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chroma && !in_eol) |=> !wr_valid);
  assert_sof_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && emit_c) |=> (wr_addr == $past(cfg_base_addr[ADDR_W-1:2])));
endmodule

// File: tb/tb_luma_bin_packer.sv
module tb_luma_bin_packer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_bin_en;
  logic [7:0]  cfg_thresh;
  logic [31:0] cfg_base_addr;
  logic [13:0] cfg_stride;
  logic        in_valid, in_chroma, in_sof, in_eol;
  logic [7:0]  in_data;
  logic        wr_valid;
  logic [29:0] wr_addr;
  logic [31:0] wr_data;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  logic [61:0] exp_q[$];
  logic [7:0]  line_buf[0:255];
  int          line_len;
  int          m_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  luma_bin_packer dut (
    .clk(clk), .rst_n(rst_n), .cfg_bin_en(cfg_bin_en), .cfg_thresh(cfg_thresh),
    .cfg_base_addr(cfg_base_addr), .cfg_stride(cfg_stride), .in_valid(in_valid),
    .in_chroma(in_chroma), .in_sof(in_sof), .in_eol(in_eol), .in_data(in_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n === 1'b1 && wr_valid === 1'b1) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: unexpected write addr=%h data=%h, expected none", cur_req, wr_addr, wr_data);
      end else begin
        logic [61:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          n_bad++;
          $display("FAIL %s: got addr=%h data=%h, expected addr=%h data=%h",
                   cur_req, wr_addr, wr_data, e[61:32], e[31:0]);
        end
      end
    end
  end

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout, expected completion");
    summary_and_end();
  end

  function automatic logic [7:0] pix(int ln, int i, int seed);
    return 8'((i * 37 + ln * 11 + seed * 53) & 255);
  endfunction

  task automatic fill_line(int n, int seed);
    line_len = n;
    for (int i = 0; i < n; i++) line_buf[i] = pix(m_line, i, seed);
  endtask

  // driver: builds expected words, then drives the line
  task automatic send_line(input bit sof, input bit mix);
    logic [31:0] w;
    logic [29:0] sw, lbase;
    int fill, widx, per;
    if (sof) m_line = 0;
    sw    = cfg_bin_en ? 30'(cfg_stride >> 5) : 30'(cfg_stride >> 2);
    lbase = cfg_base_addr[31:2] + 30'(m_line) * sw;
    per   = cfg_bin_en ? 32 : 4;
    w = '0; fill = 0; widx = 0;
    for (int i = 0; i < line_len; i++) begin
      logic [7:0] v;
      bit last;
      v = line_buf[i];
      last = (i == line_len - 1);
      if (cfg_bin_en) w[31 - fill] = (v >= cfg_thresh);
      else            w[fill*8 +: 8] = v;
      fill++;
      if (fill == per || last) begin
        exp_q.push_back({lbase + 30'(widx), w});
        widx++; w = '0; fill = 0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_chroma = 1'b0; in_data = v;
      in_sof = sof && (i == 0); in_eol = last && !mix;
      if (mix) begin
        @(negedge clk);
        in_chroma = 1'b1; in_data = 8'(i * 91 + 7); in_sof = 1'b0; in_eol = last;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_chroma = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    m_line++;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_drained();
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d writes missing, expected 0", cur_req, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_bin_en = 1'b1; cfg_thresh = 8'h80; cfg_base_addr = 32'h1000; cfg_stride = 14'd96;
    in_valid = 1'b0; in_chroma = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_data = 8'h00;
    m_line = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    repeat (4) begin
      @(negedge clk);
      n_cmp++;
      if (wr_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R1: wr_valid=%b, expected 0", wr_valid);
      end
    end

    // R3 R6 R7 R10 R11: one-bit mode, full words plus a partial tail
    cur_req = "R3_R6_R7";
    fill_line(70, 1); send_line(1'b1, 1'b0);
    fill_line(70, 2); send_line(1'b0, 1'b0);
    fill_line(33, 3); send_line(1'b0, 1'b0);
    check_drained();

    // R2: threshold boundary values
    cur_req = "R2";
    cfg_thresh = 8'h40;
    line_len = 8;
    line_buf[0] = 8'h3F; line_buf[1] = 8'h40; line_buf[2] = 8'h41; line_buf[3] = 8'h00;
    line_buf[4] = 8'hFF; line_buf[5] = 8'h40; line_buf[6] = 8'h3F; line_buf[7] = 8'h80;
    send_line(1'b1, 1'b0);
    cfg_thresh = 8'hFF;
    line_buf[0] = 8'hFE; line_buf[1] = 8'hFF;
    send_line(1'b0, 1'b0);
    cfg_thresh = 8'h00;
    send_line(1'b0, 1'b0);
    check_drained();

    // R8: one-bit stride low bits ignored (100 px -> 3 words)
    cur_req = "R8_R7";
    cfg_thresh = 8'h70; cfg_stride = 14'd100;
    fill_line(40, 4); send_line(1'b1, 1'b0);
    fill_line(40, 5); send_line(1'b0, 1'b0);
    check_drained();

    // R4 R9 R8: eight-bit mode, unaligned base and stride
    cur_req = "R4_R9_R8";
    cfg_bin_en = 1'b0; cfg_base_addr = 32'h0000_2003; cfg_stride = 14'd10;
    fill_line(7, 6); send_line(1'b1, 1'b0);
    fill_line(7, 7); send_line(1'b0, 1'b0);
    fill_line(9, 8); send_line(1'b0, 1'b0);
    check_drained();

    // R5 R6: chroma interleaved, eight-bit, line ends on word boundary
    cur_req = "R5_R6";
    cfg_base_addr = 32'h0000_4000; cfg_stride = 14'd16;
    fill_line(8, 9);  send_line(1'b1, 1'b1);
    fill_line(6, 10); send_line(1'b0, 1'b1);
    check_drained();

    // R5: chroma interleaved, one-bit mode
    cur_req = "R5_R2";
    cfg_bin_en = 1'b1; cfg_thresh = 8'h90; cfg_stride = 14'd64;
    fill_line(45, 11); send_line(1'b1, 1'b1);
    fill_line(32, 12); send_line(1'b0, 1'b1);
    check_drained();

    // R10: new frame restarts at base
    cur_req = "R10";
    cfg_base_addr = 32'h0001_0000;
    fill_line(20, 13); send_line(1'b1, 1'b0);
    fill_line(20, 14); send_line(1'b1, 1'b0);
    check_drained();

    // R11: all writes arrived with nothing extra
    cur_req = "R11";
    repeat (5) @(negedge clk);
    check_drained();
    summary_and_end();
  end
endmodule